// File: doc/BRIEF.md
# Fetch Branch Target Predictor

This block steers the fetch address of a 32-bit in-order pipeline. Each cycle it looks up the current fetch address in a small direct-mapped table. Each table entry holds a valid flag, an address tag, a branch target and a 2-bit saturating direction counter.

When the lookup hits and the counter predicts taken, the next fetch address is the stored target. On a miss, or on a hit that predicts not taken, the next fetch address is the sequential address (fetch address plus 4).

The prediction travels down the pipeline with the branch. When the branch resolves in execute, the pipeline presents the real outcome together with the prediction that was used. The block compares the two and raises a flush on any disagreement. With the flush it gives a repair address to restart fetch.

In the same cycle the block writes the resolved outcome back into the table. On a hit it trains the direction counter and refreshes the target. A branch that missed in the table and turned out taken gets a new entry.

Top module: `btb_predictor`

## Requirements
- R1: After reset every entry is invalid, so every lookup reports `pred_hit`=0 until a resolved branch has written an entry.
- R2: On a lookup miss, `pred_taken`=0 and `next_pc` equals `fetch_pc`+4.
- R3: A lookup hits when the entry at index `fetch_pc[5:2]` is valid and its tag equals `fetch_pc[31:6]`. On a hit whose counter is 2 or 3, `pred_taken`=1 and `next_pc` is the stored target.
- R4: On a hit whose counter is 0 or 1, `pred_hit`=1, `pred_taken`=0 and `next_pc` equals `fetch_pc`+4.
- R5: With `ex_valid`=1, `flush` is 1 when either of these holds: `ex_taken` differs from `ex_pred_taken`, or both are 1 and `ex_target` differs from `ex_pred_target`. In every other case `flush` is 0, and it is always 0 when `ex_valid`=0.
- R6: While `flush` is 1, `repair_pc` is `ex_target` if `ex_taken`=1 and `ex_pc`+4 otherwise.
- R7: When a resolving branch misses in the table and is taken, its entry is written with a valid flag, the tag of `ex_pc`, target `ex_target` and counter 2. A resolving branch that misses and is not taken leaves the table unchanged.
- R8: When a resolving branch hits, its counter counts up on taken (saturating at 3) and down on not taken (saturating at 0). The stored target is replaced by `ex_target` only when the branch is taken.
- R9: A lookup and a resolution in the same cycle are both served. The lookup sees the table as it was before that cycle's write.
- R10: Two addresses that share an index but differ in tag do not alias. The second one misses, and allocating it replaces the first, which then misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_pc | input | 32 | Address being fetched this cycle |
| pred_hit | output | 1 | Lookup found a matching valid entry |
| pred_taken | output | 1 | Lookup predicts a taken branch |
| next_pc | output | 32 | Fetch address for the next cycle |
| ex_valid | input | 1 | A branch resolves in execute this cycle |
| ex_pc | input | 32 | Address of the resolving branch |
| ex_taken | input | 1 | Real direction of the resolving branch |
| ex_target | input | 32 | Computed target of the resolving branch |
| ex_pred_taken | input | 1 | Direction that was predicted for it at fetch |
| ex_pred_target | input | 32 | Target that was predicted for it at fetch |
| flush | output | 1 | Younger fetched instructions must be discarded |
| repair_pc | output | 32 | Address to restart fetch from when flushing |

## Verification
Several properties are checked on every cycle:
- sequential `next_pc` on a miss or on a not-taken hit;
- flush on a direction or target mismatch, and never without `ex_valid`;
- the choice of repair address;
- allocation only for a missed taken branch;
- at most one kind of table write per cycle;
- a hit on the address trained by the previous taken resolution.

The scenarios show what no single-cycle property can see, using a reference table kept in the bench:
- the counter walking and saturating at both ends;
- target refresh;
- a lookup that sees the old table while a write lands in the same cycle;
- eviction of a same-index neighbour;
- the cold state after reset.

// File: rtl/btb_pkg.sv
package btb_pkg;

  // 2-bit saturating direction counter; the upper bit is the prediction
  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_ALLOC = 2'd2;
  localparam ctr_t CTR_MAX   = 2'd3;
  localparam ctr_t CTR_MIN   = 2'd0;

  function automatic logic ctr_says_taken(input ctr_t c);
    return c[1];
  endfunction

  function automatic ctr_t ctr_step(input ctr_t c, input logic taken);
    ctr_t r;
    if (taken) r = (c == CTR_MAX) ? CTR_MAX : c + 2'd1;
    else       r = (c == CTR_MIN) ? CTR_MIN : c - 2'd1;
    return r;
  endfunction

endpackage

// File: rtl/btb_store.sv
module btb_store
  import btb_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int IDX_W   = 4,
  parameter int TAG_W   = 26,
  parameter int ADDR_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  // fetch-side read port
  input  logic [IDX_W-1:0]  fa_idx,
  output logic              fa_valid,
  output logic [TAG_W-1:0]  fa_tag,
  output logic [ADDR_W-1:0] fa_tgt,
  output ctr_t              fa_ctr,
  // execute-side read port
  input  logic [IDX_W-1:0]  xb_idx,
  output logic              xb_valid,
  output logic [TAG_W-1:0]  xb_tag,
  output ctr_t              xb_ctr,
  // write port
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  ctr_t              wr_ctr,
  input  logic              wr_tgt_en,
  input  logic [ADDR_W-1:0] wr_tgt
);

  logic [ENTRIES-1:0] vld;
  logic [TAG_W-1:0]   tag_mem [ENTRIES];
  logic [ADDR_W-1:0]  tgt_mem [ENTRIES];
  ctr_t               ctr_mem [ENTRIES];

  // one reset flop per entry for the valid flag
  generate
    for (genvar e = 0; e < ENTRIES; e++) begin : g_slot
      localparam logic [IDX_W-1:0] SLOT = IDX_W'(e);
      logic v_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      v_q <= 1'b0;
        else if (wr_en && wr_idx == SLOT) v_q <= 1'b1;
      end
      assign vld[e] = v_q;
    end
  endgenerate

  // payload storage needs no reset: the valid flag guards it
  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_mem[wr_idx] <= wr_tag;
      ctr_mem[wr_idx] <= wr_ctr;
    end
    if (wr_tgt_en) tgt_mem[wr_idx] <= wr_tgt;
  end

  assign fa_valid = vld[fa_idx];
  assign fa_tag   = tag_mem[fa_idx];
  assign fa_tgt   = tgt_mem[fa_idx];
  assign fa_ctr   = ctr_mem[fa_idx];

  assign xb_valid = vld[xb_idx];
  assign xb_tag   = tag_mem[xb_idx];
  assign xb_ctr   = ctr_mem[xb_idx];

endmodule

// File: rtl/btb_lookup.sv
module btb_lookup
  import btb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int TAG_W  = 26
) (
  input  logic [TAG_W-1:0]  pc_tag,
  input  logic [ADDR_W-1:0] pc_seq,
  input  logic              ent_valid,
  input  logic [TAG_W-1:0]  ent_tag,
  input  logic [ADDR_W-1:0] ent_tgt,
  input  ctr_t              ent_ctr,
  output logic              hit,
  output logic              pred_taken,
  output logic [ADDR_W-1:0] next_pc
);

  assign hit        = ent_valid && (ent_tag == pc_tag);
  assign pred_taken = hit && ctr_says_taken(ent_ctr);
  assign next_pc    = pred_taken ? ent_tgt : pc_seq;

endmodule

// File: rtl/btb_resolve.sv
module btb_resolve #(
  parameter int ADDR_W = 32
) (
  input  logic              ex_valid,
  input  logic              ex_taken,
  input  logic [ADDR_W-1:0] ex_target,
  input  logic [ADDR_W-1:0] ex_seq,
  input  logic              ex_pred_taken,
  input  logic [ADDR_W-1:0] ex_pred_target,
  output logic              dir_miss,
  output logic              tgt_miss,
  output logic              flush,
  output logic [ADDR_W-1:0] repair_pc
);

  assign dir_miss  = ex_valid && (ex_taken != ex_pred_taken);
  // target only matters when both sides agree the branch is taken
  assign tgt_miss  = ex_valid && ex_taken && ex_pred_taken &&
                     (ex_target != ex_pred_target);
  assign flush     = dir_miss || tgt_miss;
  assign repair_pc = ex_taken ? ex_target : ex_seq;

endmodule

// File: rtl/btb_update.sv
module btb_update
  import btb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 4,
  parameter int TAG_W  = 26
) (
  input  logic              ex_valid,
  input  logic              ex_taken,
  input  logic [ADDR_W-1:0] ex_target,
  input  logic [IDX_W-1:0]  ex_idx,
  input  logic [TAG_W-1:0]  ex_tag,
  input  logic              ent_valid,
  input  logic [TAG_W-1:0]  ent_tag,
  input  ctr_t              ent_ctr,
  output logic              ex_hit,
  output logic              alloc_evt,
  output logic              train_evt,
  output logic              wr_en,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [TAG_W-1:0]  wr_tag,
  output ctr_t              wr_ctr,
  output logic              wr_tgt_en,
  output logic [ADDR_W-1:0] wr_tgt
);

  assign ex_hit    = ent_valid && (ent_tag == ex_tag);
  assign train_evt = ex_valid && ex_hit;
  assign alloc_evt = ex_valid && !ex_hit && ex_taken;

  assign wr_en     = train_evt || alloc_evt;
  assign wr_idx    = ex_idx;
  assign wr_tag    = ex_tag;
  assign wr_ctr    = alloc_evt ? CTR_ALLOC : ctr_step(ent_ctr, ex_taken);
  assign wr_tgt_en = ex_valid && ex_taken;
  assign wr_tgt    = ex_target;

endmodule

// File: rtl/btb_predictor.sv
module btb_predictor
  import btb_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int ENTRIES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] fetch_pc,
  output logic              pred_hit,
  output logic              pred_taken,
  output logic [ADDR_W-1:0] next_pc,
  input  logic              ex_valid,
  input  logic [ADDR_W-1:0] ex_pc,
  input  logic              ex_taken,
  input  logic [ADDR_W-1:0] ex_target,
  input  logic              ex_pred_taken,
  input  logic [ADDR_W-1:0] ex_pred_target,
  output logic              flush,
  output logic [ADDR_W-1:0] repair_pc
);

  localparam int IDX_W = $clog2(ENTRIES);
  localparam int TAG_W = ADDR_W - IDX_W - 2;

  function automatic logic [IDX_W-1:0] idx_of(input logic [ADDR_W-1:0] pc);
    return pc[IDX_W+1:2];
  endfunction

  function automatic logic [TAG_W-1:0] tag_of(input logic [ADDR_W-1:0] pc);
    return pc[ADDR_W-1:IDX_W+2];
  endfunction

  function automatic logic [ADDR_W-1:0] seq_of(input logic [ADDR_W-1:0] pc);
    return pc + ADDR_W'(4);
  endfunction

  // named internal events, visible to the bound checker
  logic              ex_hit;
  logic              alloc_evt;
  logic              train_evt;
  logic              dir_miss;
  logic              tgt_miss;

  logic              fa_valid, xb_valid;
  logic [TAG_W-1:0]  fa_tag, xb_tag;
  logic [ADDR_W-1:0] fa_tgt;
  ctr_t              fa_ctr, xb_ctr;

  logic              wr_en, wr_tgt_en;
  logic [IDX_W-1:0]  wr_idx;
  logic [TAG_W-1:0]  wr_tag;
  ctr_t              wr_ctr;
  logic [ADDR_W-1:0] wr_tgt;

  btb_store #(
    .ENTRIES(ENTRIES), .IDX_W(IDX_W), .TAG_W(TAG_W), .ADDR_W(ADDR_W)
  ) store_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .fa_idx   (idx_of(fetch_pc)),
    .fa_valid (fa_valid),
    .fa_tag   (fa_tag),
    .fa_tgt   (fa_tgt),
    .fa_ctr   (fa_ctr),
    .xb_idx   (idx_of(ex_pc)),
    .xb_valid (xb_valid),
    .xb_tag   (xb_tag),
    .xb_ctr   (xb_ctr),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_tag   (wr_tag),
    .wr_ctr   (wr_ctr),
    .wr_tgt_en(wr_tgt_en),
    .wr_tgt   (wr_tgt)
  );

  btb_lookup #(.ADDR_W(ADDR_W), .TAG_W(TAG_W)) lookup_i (
    .pc_tag    (tag_of(fetch_pc)),
    .pc_seq    (seq_of(fetch_pc)),
    .ent_valid (fa_valid),
    .ent_tag   (fa_tag),
    .ent_tgt   (fa_tgt),
    .ent_ctr   (fa_ctr),
    .hit       (pred_hit),
    .pred_taken(pred_taken),
    .next_pc   (next_pc)
  );

  btb_resolve #(.ADDR_W(ADDR_W)) resolve_i (
    .ex_valid      (ex_valid),
    .ex_taken      (ex_taken),
    .ex_target     (ex_target),
    .ex_seq        (seq_of(ex_pc)),
    .ex_pred_taken (ex_pred_taken),
    .ex_pred_target(ex_pred_target),
    .dir_miss      (dir_miss),
    .tgt_miss      (tgt_miss),
    .flush         (flush),
    .repair_pc     (repair_pc)
  );

  btb_update #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .TAG_W(TAG_W)) update_i (
    .ex_valid (ex_valid),
    .ex_taken (ex_taken),
    .ex_target(ex_target),
    .ex_idx   (idx_of(ex_pc)),
    .ex_tag   (tag_of(ex_pc)),
    .ent_valid(xb_valid),
    .ent_tag  (xb_tag),
    .ent_ctr  (xb_ctr),
    .ex_hit   (ex_hit),
    .alloc_evt(alloc_evt),
    .train_evt(train_evt),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_tag   (wr_tag),
    .wr_ctr   (wr_ctr),
    .wr_tgt_en(wr_tgt_en),
    .wr_tgt   (wr_tgt)
  );

endmodule

// File: rtl/btb_checker.sv
module btb_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] fetch_pc,
  input logic              pred_hit,
  input logic              pred_taken,
  input logic [ADDR_W-1:0] next_pc,
  input logic              ex_valid,
  input logic [ADDR_W-1:0] ex_pc,
  input logic              ex_taken,
  input logic [ADDR_W-1:0] ex_target,
  input logic              ex_pred_taken,
  input logic [ADDR_W-1:0] ex_pred_target,
  input logic              flush,
  input logic [ADDR_W-1:0] repair_pc,
  input logic              ex_hit,
  input logic              alloc_evt,
  input logic              train_evt
);

  AST_MISS_SEQUENTIAL: assert property (@(posedge clk) disable iff (!rst_n)
    !pred_hit |-> (!pred_taken && next_pc == fetch_pc + ADDR_W'(4))); // R2

  AST_WEAK_HIT_SEQUENTIAL: assert property (@(posedge clk) disable iff (!rst_n)
    (pred_hit && !pred_taken) |-> next_pc == fetch_pc + ADDR_W'(4)); // R4

  AST_FLUSH_ON_DIRECTION: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_valid && ex_taken != ex_pred_taken) |-> flush); // R5

  AST_FLUSH_ON_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_valid && ex_taken && ex_pred_taken && ex_target != ex_pred_target) |-> flush); // R5

  AST_FLUSH_NEEDS_BRANCH: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> ex_valid); // R5

  AST_REPAIR_ADDRESS: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> repair_pc == (ex_taken ? ex_target : ex_pc + ADDR_W'(4))); // R6

  AST_ALLOC_TAKEN_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_evt |-> (ex_valid && ex_taken && !ex_hit)); // R7

  AST_SINGLE_WRITE_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({alloc_evt, train_evt})); // R8

  AST_TAKEN_IS_LEARNED: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_valid && ex_taken) ##1 (fetch_pc == $past(ex_pc)) |-> pred_hit); // R7

endmodule

bind btb_predictor btb_checker #(.ADDR_W(ADDR_W)) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .fetch_pc      (fetch_pc),
  .pred_hit      (pred_hit),
  .pred_taken    (pred_taken),
  .next_pc       (next_pc),
  .ex_valid      (ex_valid),
  .ex_pc         (ex_pc),
  .ex_taken      (ex_taken),
  .ex_target     (ex_target),
  .ex_pred_taken (ex_pred_taken),
  .ex_pred_target(ex_pred_target),
  .flush         (flush),
  .repair_pc     (repair_pc),
  .ex_hit        (ex_hit),
  .alloc_evt     (alloc_evt),
  .train_evt     (train_evt)
);

// File: tb/btb_predictor_tb_top.sv
module btb_predictor_tb_top;

  localparam int CLK_P = 10;
  localparam int NSLOT = 16;
  localparam int TSH   = 6;   // 2 offset bits + 4 index bits

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] fetch_pc;
  logic        pred_hit, pred_taken;
  logic [31:0] next_pc;
  logic        ex_valid;
  logic [31:0] ex_pc;
  logic        ex_taken;
  logic [31:0] ex_target;
  logic        ex_pred_taken;
  logic [31:0] ex_pred_target;
  logic        flush;
  logic [31:0] repair_pc;

  always #(CLK_P/2) clk = ~clk;

  btb_predictor dut_i (
    .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc),
    .pred_hit(pred_hit), .pred_taken(pred_taken), .next_pc(next_pc),
    .ex_valid(ex_valid), .ex_pc(ex_pc), .ex_taken(ex_taken),
    .ex_target(ex_target), .ex_pred_taken(ex_pred_taken),
    .ex_pred_target(ex_pred_target), .flush(flush), .repair_pc(repair_pc)
  );

  typedef struct {
    logic [31:0] nxt;
    logic        hit;
    logic        tkn;
    logic        fl;
    logic [31:0] rep;
    string       req;
  } exp_t;

  exp_t exp_q[$];
  int   n_vec = 0;
  int   n_bad = 0;
  bit   done  = 0;

  // reference table
  bit          m_v   [NSLOT];
  logic [31:0] m_tag [NSLOT];
  logic [31:0] m_tgt [NSLOT];
  int          m_ctr [NSLOT];

  function automatic int slot(input logic [31:0] pc);
    return int'((pc >> 2) % NSLOT);
  endfunction

  // drive one cycle and record what the outputs must show
  task automatic apply(input logic [31:0] fpc, input logic xv, input logic [31:0] xpc,
                       input logic xt, input logic [31:0] xtg,
                       input logic xpt, input logic [31:0] xptg, input string req);
    exp_t e;
    int   s;
    bit   h;
    @(negedge clk);
    fetch_pc = fpc; ex_valid = xv; ex_pc = xpc; ex_taken = xt;
    ex_target = xtg; ex_pred_taken = xpt; ex_pred_target = xptg;
    s     = slot(fpc);
    e.hit = m_v[s] && (m_tag[s] == (fpc >> TSH));
    e.tkn = e.hit && (m_ctr[s] >= 2);
    e.nxt = e.tkn ? m_tgt[s] : fpc + 32'd4;
    e.fl  = xv && ((xt != xpt) || (xt && xtg != xptg));
    e.rep = xt ? xtg : xpc + 32'd4;
    e.req = req;
    exp_q.push_back(e);
    // table changes at the coming edge, after the lookup above
    if (xv) begin
      s = slot(xpc);
      h = m_v[s] && (m_tag[s] == (xpc >> TSH));
      if (h) begin
        if (xt) begin
          if (m_ctr[s] < 3) m_ctr[s]++;
          m_tgt[s] = xtg;
        end else if (m_ctr[s] > 0) m_ctr[s]--;
      end else if (xt) begin
        m_v[s] = 1; m_tag[s] = xpc >> TSH; m_tgt[s] = xtg; m_ctr[s] = 2;
      end
    end
  endtask

  task automatic look(input logic [31:0] fpc, input string req);
    apply(fpc, 1'b0, 32'h0, 1'b0, 32'h0, 1'b0, 32'h0, req);
  endtask

  task automatic resolve(input logic [31:0] xpc, input logic xt, input logic [31:0] xtg,
                         input logic xpt, input logic [31:0] xptg, input string req);
    apply(32'h0000_8000, 1'b1, xpc, xt, xtg, xpt, xptg, req);
  endtask

  // monitor: compare a quarter period after the driving edge
  initial begin
    forever begin
      @(negedge clk);
      #(CLK_P/4);
      if (exp_q.size() > 0) begin
        exp_t e;
        bit   bad;
        e   = exp_q.pop_front();
        bad = 0;
        n_vec++;
        if (pred_hit !== e.hit) begin
          bad = 1;
          $display("FAIL %s pred_hit got %0b exp %0b", e.req, pred_hit, e.hit);
        end
        if (pred_taken !== e.tkn) begin
          bad = 1;
          $display("FAIL %s pred_taken got %0b exp %0b", e.req, pred_taken, e.tkn);
        end
        if (next_pc !== e.nxt) begin
          bad = 1;
          $display("FAIL %s next_pc got %h exp %h", e.req, next_pc, e.nxt);
        end
        if (flush !== e.fl) begin
          bad = 1;
          $display("FAIL %s flush got %0b exp %0b", e.req, flush, e.fl);
        end
        if (e.fl && repair_pc !== e.rep) begin
          bad = 1;
          $display("FAIL %s repair_pc got %h exp %h", e.req, repair_pc, e.rep);
        end
        if (bad) n_bad++;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired: vectors %0d exp %0d", n_vec, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] lcg;
    for (int i = 0; i < NSLOT; i++) begin
      m_v[i] = 0; m_tag[i] = 0; m_tgt[i] = 0; m_ctr[i] = 0;
    end
    rst_n = 1'b0; fetch_pc = 0; ex_valid = 0; ex_pc = 0; ex_taken = 0;
    ex_target = 0; ex_pred_taken = 0; ex_pred_target = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: cold table
    look(32'h0000_0104, "R1");
    look(32'h0000_0000, "R1");
    look(32'h0000_003C, "R1");
    // R2: miss gives sequential
    look(32'h0000_1FFC, "R2");

    // R7 + R9: allocate while fetching the same address (must still miss)
    apply(32'h0000_0104, 1'b1, 32'h0000_0104, 1'b1, 32'h0000_0200, 1'b0, 32'h0, "R9");
    // R3: new entry predicts taken
    look(32'h0000_0104, "R3");
    // R5/R6: predicted taken, went not taken -> repair to sequential, counter 2->1
    resolve(32'h0000_0104, 1'b0, 32'h0000_0200, 1'b1, 32'h0000_0200, "R6");
    look(32'h0000_0104, "R4");
    // R7: missed not-taken branch allocates nothing
    resolve(32'h0000_0300, 1'b0, 32'h0000_0400, 1'b0, 32'h0, "R7");
    look(32'h0000_0300, "R7");
    // R8: taken again with a new target: counter 1->2, target refreshed
    resolve(32'h0000_0104, 1'b1, 32'h0000_0240, 1'b0, 32'h0, "R8");
    look(32'h0000_0104, "R8");
    // R8: saturate high then one not-taken still predicts taken
    resolve(32'h0000_0104, 1'b1, 32'h0000_0240, 1'b1, 32'h0000_0240, "R5");
    resolve(32'h0000_0104, 1'b1, 32'h0000_0240, 1'b1, 32'h0000_0240, "R8");
    resolve(32'h0000_0104, 1'b0, 32'h0000_0240, 1'b1, 32'h0000_0240, "R8");
    look(32'h0000_0104, "R8");
    // R5: target mismatch when both taken
    resolve(32'h0000_0104, 1'b1, 32'h0000_0280, 1'b1, 32'h0000_0240, "R5");
    look(32'h0000_0104, "R8");
    // R5: mismatching fields but no branch -> no flush, no table change
    apply(32'h0000_0104, 1'b0, 32'h0000_0104, 1'b0, 32'h0000_0999, 1'b1, 32'h0, "R5");
    look(32'h0000_0104, "R5");
    // R8: walk down and saturate low, entry still hits
    for (int k = 0; k < 5; k++)
      resolve(32'h0000_0104, 1'b0, 32'h0, 1'b0, 32'h0, "R8");
    look(32'h0000_0104, "R4");
    // R10: same index, other tag
    look(32'h0000_0144, "R10");
    resolve(32'h0000_0144, 1'b1, 32'h0000_0500, 1'b0, 32'h0, "R10");
    look(32'h0000_0144, "R10");
    look(32'h0000_0104, "R10");

    // mixed traffic over 24 addresses so indices collide
    lcg = 32'h1234_5678;
    for (int n = 0; n < 400; n++) begin
      logic [31:0] fpc, xpc, xtg, ptg;
      logic        xv, xt, pt;
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      fpc = 32'h0000_0100 + ((lcg >> 8) % 24) * 4;
      xpc = 32'h0000_0100 + ((lcg >> 16) % 24) * 4;
      xv  = lcg[3] | lcg[4];
      xt  = lcg[5];
      pt  = lcg[6];
      xtg = 32'h0000_2000 + ((lcg >> 24) % 4) * 4;
      ptg = lcg[7] ? xtg : xtg + 32'd4;
      apply(fpc, xv, xpc, xt, xtg, pt, ptg, "R5");
    end

    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule